// File: doc/BRIEF.md
# SCL Phase Timer with Clock-Stretch Hold-Off

This block times the low and high phases of the clock line of an I2C master. A sequencer asks it to start an interval. The block copies a 7-bit reload value into a down-counter, and the counter steps once on every tick enable. The tick enable fires twice per instruction cycle. When the count steps from one to zero, the block raises a single-cycle timeout, and the count then stays at zero.

A master that lets SCL float high uses a separate release request. After that request the counter does not move. It waits until the resynchronized clock line actually reads high, because a slave may be holding it low. Only then does it reload and time the high phase. The high phase therefore always lasts at least one full count, however long the slave stretched the clock. The raw SCL level enters through a two-flop synchronizer.

Top module: `scl_baud_gen`

## Requirements
- R1: While reset is high and in the first cycle after reset, count reads 0 and timeout is low. Ticks arriving after reset, with no request, produce no timeout and leave count at 0.
- R2: A clock edge with load_req high copies reload_val into count, whatever tick_en is.
- R3: While an interval runs, count drops by exactly 1 at each clock edge with tick_en high and stays unchanged at edges with tick_en low.
- R4: timeout is high for exactly one cycle: the cycle in which an interval runs, tick_en is high and count is 1, with no request present. At the next edge count becomes 0.
- R5: Once an interval has timed out, count stays at 0 and timeout stays low on later ticks until a new load or release request. It never wraps below zero.
- R6: A reload value of 0 raises timeout on the first tick after the load, and count stays 0.
- R7: After release_req, count is frozen and timeout stays low for as long as the synchronized SCL reads low, with any number of ticks.
- R8: After a release, when scl_pin goes high before clock edge k, count equals reload_val after edge k+2 and not earlier. This reflects the two synchronizer stages.
- R9: load_req takes priority over release_req when both are high. Either request stops a running interval, and timeout is low in any cycle that carries a request.
- R10: Once the reload after a release has happened, timeout comes on exactly the reload_val-th tick after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, two pulses per instruction cycle |
| reload_val | input | 7 | Interval length in ticks |
| load_req | input | 1 | Start an interval now from reload_val |
| release_req | input | 1 | SCL released: hold until SCL reads high, then reload |
| scl_pin | input | 1 | Raw SCL level from the pad |
| timeout | output | 1 | One-cycle pulse on the tick where count goes 1 to 0 |
| count | output | 7 | Current counter value |

## Verification
The checker watches every cycle for the following:
- the one-step decrement and the hold when no tick arrives;
- the single-cycle width of timeout and the zero count that follows it;
- the floor at zero;
- the frozen count during the wait;
- the load copy.

Some behaviours span many cycles, and only the bench scenarios can show them. These are the exact edge at which a rising pin level turns into a reload, a wait that lasts indefinitely, the full-length high phase after a stretch, request priority, and the zero and maximum reload values. A bench model tracks these cycle by cycle.

// File: rtl/sclbg_pkg.sv
package sclbg_pkg;

    localparam int SCLBG_CNT_W    = 7;
    localparam int SCLBG_SYNC_DEF = 2;

    typedef enum logic [1:0] {
        BG_IDLE = 2'd0,
        BG_RUN  = 2'd1,
        BG_WAIT = 2'd2,
        BG_DONE = 2'd3
    } bg_state_e;

    typedef struct packed {
        logic load;
        logic dec;
    } cnt_cmd_t;

    // true when a tick at this count ends the interval
    function automatic logic last_step(input logic [31:0] v);
        return v <= 32'd1;
    endfunction

endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("bg_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/bg_down_counter.sv
module bg_down_counter
    import sclbg_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_cmd_t     cmd,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (cmd.load) cnt <= load_val;
        else if (cmd.dec)  cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/bg_ctrl.sv
module bg_ctrl
    import sclbg_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load_req,
    input  logic         release_req,
    input  logic         scl_hi,
    input  logic [W-1:0] cnt,
    output cnt_cmd_t     cmd,
    output logic         timeout,
    output bg_state_e    st
);
    bg_state_e nxt;
    logic      at_last;
    logic      nonzero;

    assign at_last = last_step(32'(cnt));
    assign nonzero = (cnt != '0);

    always_comb begin
        nxt      = st;
        cmd      = '0;
        timeout  = 1'b0;
        if (load_req) begin
            cmd.load = 1'b1;
            nxt      = BG_RUN;
        end else if (release_req) begin
            nxt = BG_WAIT;
        end else begin
            unique case (st)
                BG_WAIT: begin
                    if (scl_hi) begin
                        cmd.load = 1'b1;
                        nxt      = BG_RUN;
                    end
                end
                BG_RUN: begin
                    if (tick_en) begin
                        cmd.dec = nonzero;
                        if (at_last) begin
                            timeout = 1'b1;
                            nxt     = BG_DONE;
                        end
                    end
                end
                default: nxt = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= BG_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/scl_baud_gen.sv
module scl_baud_gen
    import sclbg_pkg::*;
#(
    parameter int CNT_W       = SCLBG_CNT_W,
    parameter int SYNC_STAGES = SCLBG_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_req,
    input  logic             release_req,
    input  logic             scl_pin,
    output logic             timeout,
    output logic [CNT_W-1:0] count
);
    logic      scl_hi;
    cnt_cmd_t  cmd;
    bg_state_e st;

    bg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_pin),
        .q   (scl_hi)
    );

    bg_ctrl #(.W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .load_req    (load_req),
        .release_req (release_req),
        .scl_hi      (scl_hi),
        .cnt         (count),
        .cmd         (cmd),
        .timeout     (timeout),
        .st          (st)
    );

    bg_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (reload_val),
        .cnt      (count)
    );
endmodule

// File: rtl/scl_baud_gen_chk.sv
module scl_baud_gen_chk
    import sclbg_pkg::*;
#(
    parameter int W = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic         load_req,
    input logic         release_req,
    input logic [W-1:0] reload_val,
    input logic         timeout,
    input logic [W-1:0] count,
    input bg_state_e    st,
    input logic         scl_hi
);
    logic no_req;
    assign no_req = !load_req && !release_req;

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (count == '0));

    a_r2_load_copy: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (count == $past(reload_val)));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (st == BG_RUN && tick_en && no_req && count > W'(1))
        |=> (count == $past(count) - W'(1)));

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && no_req && st != BG_WAIT) |=> $stable(count));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    a_r4_zero_after: assert property (@(posedge clk) disable iff (rst)
        timeout |=> (count == '0));

    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && no_req && st != BG_WAIT) |=> (count == '0));

    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (st == BG_WAIT && !scl_hi && !load_req) |=> $stable(count));

    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == BG_WAIT) |-> !timeout);

    a_r9_req_quiet: assert property (@(posedge clk) disable iff (rst)
        (load_req || release_req) |-> !timeout);
endmodule

bind scl_baud_gen scl_baud_gen_chk #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .load_req    (load_req),
    .release_req (release_req),
    .reload_val  (reload_val),
    .timeout     (timeout),
    .count       (count),
    .st          (st),
    .scl_hi      (scl_hi)
);

// File: tb/sim_scl_baud_gen.sv
`timescale 1ns/1ps
module sim_scl_baud_gen;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic         load_req = 1'b0;
    logic         release_req = 1'b0;
    logic         scl_pin = 1'b1;
    logic         timeout;
    logic [W-1:0] count;

    always #4 clk = ~clk;

    scl_baud_gen u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reload_val(reload_val),
        .load_req(load_req), .release_req(release_req), .scl_pin(scl_pin),
        .timeout(timeout), .count(count)
    );

    typedef struct {
        logic         to;
        logic [W-1:0] cnt;
        string        tag;
    } item_t;

    item_t q[$];
    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model, per requirements: 0 idle, 1 run, 2 wait, 3 done
    int           mst = 0;
    logic [W-1:0] mcnt = '0;
    logic         s1 = 1'b1, s2 = 1'b1;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit ld, input bit rel, input bit tk,
                        input bit scl, input string tag);
        item_t it;
        @(negedge clk);
        load_req = ld; release_req = rel; tick_en = tk; scl_pin = scl;
        it.to = (mst == 1) && tk && (mcnt <= 1) && !ld && !rel;
        if (ld) begin mcnt = reload_val; mst = 1; end
        else if (rel) mst = 2;
        else if (mst == 2) begin
            if (s2) begin mcnt = reload_val; mst = 1; end
        end else if (mst == 1 && tk) begin
            if (mcnt <= 1) begin mcnt = '0; mst = 3; end
            else mcnt = mcnt - 1'b1;
        end
        s2 = s1; s1 = scl;
        it.cnt = mcnt;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: timeout before the edge, count after it
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                check({it.tag, " timeout"}, int'(timeout), int'(it.to));
                @(posedge clk);
                #1;
                check({it.tag, " count"}, int'(count), int'(it.cnt));
            end
        end
    end

    task automatic finish_run();
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int edges;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset count", int'(count), 0);
        check("R1 reset timeout", int'(timeout), 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: ticks with no request do nothing
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R1");

        // R2 R3 R4 R5: load 5, tick each cycle, then past zero
        reload_val = 7'd5;
        step(1, 0, 0, 1, "R2");
        for (int i = 0; i < 8; i++) step(0, 0, 1, 1, "R4");

        // R3: alternate ticks, load 4
        reload_val = 7'd4;
        step(1, 0, 1, 1, "R2");
        for (int i = 0; i < 10; i++) step(0, 0, i[0], 1, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R5");

        // R6: reload zero
        reload_val = 7'd0;
        step(1, 0, 0, 1, "R6");
        step(0, 0, 0, 1, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R6");

        // R7: release with pin held low by a slave, long wait
        reload_val = 7'd6;
        step(1, 0, 0, 0, "R9");
        step(0, 0, 1, 0, "R3");
        step(0, 1, 1, 0, "R9");
        for (int i = 0; i < 40; i++) step(0, 0, 1, 0, "R7");
        // R8: pin goes high before edge k; reload at k+2
        reload_val = 7'd3;
        step(0, 0, 1, 1, "R8");
        step(0, 0, 1, 1, "R8");
        step(0, 0, 1, 1, "R8");
        // R10: high phase lasts reload_val ticks
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1, "R10");

        // R9: both requests at once, load wins
        reload_val = 7'd2;
        step(1, 1, 1, 1, "R9");
        step(0, 0, 1, 1, "R9");
        step(0, 1, 1, 1, "R9");
        step(0, 0, 1, 1, "R8");
        step(0, 0, 1, 1, "R8");

        // R10: maximum reload after a stretched release
        reload_val = 7'd127;
        step(0, 1, 0, 0, "R7");
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, "R7");
        edges = 0;
        for (int i = 0; i < 140; i++) step(0, 0, 1, 1, "R10");
        done = 1;
        finish_run();
    end
endmodule